// File: doc/BRIEF.md
# Receive FIFO Watermark Flow Controller

This block watches how full a 128-entry receive FIFO is and tells the remote sender, through an active-low handshake pin, when to pause and when to go on. Two 8-bit threshold codes set a stop level and a resume level. Between the two levels the handshake keeps its last state, so the pin does not chatter while the fill level drifts around one boundary. Codes 0 and 1 both mean one entry. Codes from 2 to 128 mean that many entries. Any code above 128 is treated as 128.

A select input chooses which modem pin pair carries the handshake. With the select at 0, the request-to-send pin and the clear-to-send input carry it. With the select at 1, the data-terminal-ready pin and the data-set-ready input carry it. The pin that does not carry flow control keeps its ordinary modem role and simply shows the software-controlled modem bit.

The block also returns a "remote may send" qualifier that gates the local transmitter. It is taken from the selected clear-style input after a two-flop synchronizer. When flow control is off, the qualifier is always high.

Top module: `rxwm_flow_ctrl`

## Requirements
- R1: While reset is held, both `rts_n` and `dtr_n` are low and `tx_allow` is high.
- R2: A threshold code of 0x00 or 0x01 selects a level of one entry.
- R3: A threshold code from 0x02 to 0x80 selects that many entries. Any code above 0x80 selects 128 entries.
- R4: While flow control is enabled, a FIFO count at or above the high level drives the carrying pin high (stop). The pin changes at the second rising clock edge after the count is applied.
- R5: While enabled, a count at or below the low level drives the carrying pin low (resume). A count strictly between the two levels holds the previous state.
- R6: When a count satisfies both the high and the low condition at once, stop wins and the carrying pin is driven high.
- R7: With `map_sel` = 0, `rts_n` carries the handshake and `dtr_n` equals the inverse of `sw_dtr`. With `map_sel` = 1, `dtr_n` carries the handshake and `rts_n` equals the inverse of `sw_rts`.
- R8: While `fc_en` is 0, the carrying pin shows the inverse of its software modem bit, the stop state is cleared, and `tx_allow` is high.
- R9: While enabled, `tx_allow` is high exactly when the selected clear input (`cts_n` for `map_sel` = 0, `dsr_n` for `map_sel` = 1) is low. A change on that input reaches `tx_allow` at the second rising edge.
- R10: A change of threshold code moves the handshake pin only at a clock edge. The move happens two edges after the code changes, and the pin never shows an intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_en | input | 1 | Hardware flow control enable |
| map_sel | input | 1 | 0: handshake on RTS/CTS, 1: handshake on DTR/DSR |
| fifo_count | input | 8 | Current receive FIFO fill level (0 to 128) |
| hi_code | input | 8 | Stop threshold code |
| lo_code | input | 8 | Resume threshold code |
| sw_rts | input | 1 | Software modem bit for RTS (1 = assert) |
| sw_dtr | input | 1 | Software modem bit for DTR (1 = assert) |
| cts_n | input | 1 | Asynchronous clear-to-send input, active low |
| dsr_n | input | 1 | Asynchronous data-set-ready input, active low |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| dtr_n | output | 1 | Data-terminal-ready pin, active low, registered |
| tx_allow | output | 1 | Remote may send: qualifier for the local transmitter |

## Verification
Two functions can fall in the same cycle: the stop decision and the resume decision. This happens whenever the high level is at or below the low level and the count lies inside both windows. The bench provokes it with directed inverted threshold pairs. Its random threshold draws also produce such pairs often, and it judges each one against a bench model in which stop takes priority. A second collision comes from changing `map_sel` while the stop state is set: the bench then checks that the handshake moves to the other pin and that the freed pin at once shows its software bit.

// File: rtl/rxwm_pkg.sv
// Package: shared types for the receive watermark flow controller.
// Assumes: nothing beyond standard SystemVerilog.
package rxwm_pkg;

    // Which modem pin pair carries the hardware handshake.
    typedef enum logic {
        MAP_RTS_CTS = 1'b0,
        MAP_DTR_DSR = 1'b1
    } map_sel_e;

    // Registered state of the two request-style pins (active low).
    typedef struct packed {
        logic rts_n;
        logic dtr_n;
    } modem_pins_t;

endpackage

// File: rtl/rxwm_level_decode.sv
// Module: turns an 8-bit threshold code into an effective entry level.
// Codes 0 and 1 give a level of one; codes above MAX_LVL are clamped.
// Assumes: MAX_LVL fits in LVL_W bits and the code is static or registered upstream.
module rxwm_level_decode #(
    parameter int CODE_W  = 8,
    parameter int LVL_W   = 8,
    parameter int MAX_LVL = 128
) (
    input  logic [CODE_W-1:0] code,
    output logic [LVL_W-1:0]  level
);
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_LVL);
    localparam logic [LVL_W-1:0]  LVL_MAX  = LVL_W'(MAX_LVL);
    localparam logic [LVL_W-1:0]  LVL_ONE  = LVL_W'(1);

    // Map code to level with the floor of one and the ceiling of MAX_LVL.
    always_comb begin
        if (code <= CODE_W'(1)) begin
            level = LVL_ONE;
        end else if (code > CODE_MAX) begin
            level = LVL_MAX;
        end else begin
            level = LVL_W'(code);
        end
    end
endmodule

// File: rtl/rxwm_hysteresis.sv
// Module: hysteresis state for receive-side flow control.
// The stop state sets at or above the high level and clears at or below the
// low level; stop wins when both hold. Disabled operation clears the state.
// Assumes: synchronous active-low reset; count and levels share width CNT_W.
module rxwm_hysteresis #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] hi_level,
    input  logic [CNT_W-1:0] lo_level,
    output logic             halt_q
);
    logic hit_hi;
    logic hit_lo;
    logic halt_d;

    // Compare the fill level against both watermarks.
    always_comb begin
        hit_hi = (count >= hi_level);
        hit_lo = (count <= lo_level);
    end

    // Next stop state: stop has priority, otherwise resume, otherwise hold.
    always_comb begin
        if (!enable) begin
            halt_d = 1'b0;
        end else if (hit_hi) begin
            halt_d = 1'b1;
        end else if (hit_lo) begin
            halt_d = 1'b0;
        end else begin
            halt_d = halt_q;
        end
    end

    // Hold the stop state; reset means the remote may send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt_d;
        end
    end
endmodule

// File: rtl/rxwm_sync.sv
// Module: multi-flop synchronizer for asynchronous modem inputs.
// Assumes: each bit is independent (no bus coherency needed); STAGES >= 2.
module rxwm_sync #(
    parameter int   WIDTH    = 2,
    parameter int   STAGES   = 2,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stage_q[s] <= {WIDTH{RST_VAL}};
                    end else begin
                        stage_q[s] <= async_in;
                    end
                end
            end else begin : g_next
                // Later flops let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stage_q[s] <= {WIDTH{RST_VAL}};
                    end else begin
                        stage_q[s] <= stage_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/rxwm_pin_mux.sv
// Module: routes the stop state to the selected request pin and the
// selected synchronized clear input to the transmit qualifier.
// The pin that does not carry flow control shows its software modem bit.
// Assumes: clear inputs are already synchronized; pins are registered so
// they only move at a clock edge.
module rxwm_pin_mux
    import rxwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  map_sel_e    map_sel,
    input  logic        halt,
    input  logic        sw_rts,
    input  logic        sw_dtr,
    input  logic        cts_s_n,
    input  logic        dsr_s_n,
    output modem_pins_t pins_q,
    output logic        tx_allow
);
    modem_pins_t pins_d;
    logic        clear_n;

    // Choose the value each pin should show in the next cycle.
    always_comb begin
        pins_d.rts_n = ~sw_rts;
        pins_d.dtr_n = ~sw_dtr;
        if (enable) begin
            if (map_sel == MAP_RTS_CTS) begin
                pins_d.rts_n = halt;
            end else begin
                pins_d.dtr_n = halt;
            end
        end
    end

    // Register the pins so threshold or mode changes cannot glitch them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    // Qualify the local transmitter from the selected clear input.
    always_comb begin
        clear_n  = (map_sel == MAP_RTS_CTS) ? cts_s_n : dsr_s_n;
        tx_allow = !enable || !clear_n;
    end
endmodule

// File: rtl/rxwm_flow_ctrl.sv
// Module: top of the receive FIFO watermark flow controller.
// Decodes both threshold codes, tracks the stop state with hysteresis,
// synchronizes the clear inputs and drives the selected handshake pin.
// Assumes: fifo_count is synchronous to clk; cts_n and dsr_n are asynchronous.
module rxwm_flow_ctrl
    import rxwm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int MAX_LVL     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en,
    input  logic             map_sel,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] hi_code,
    input  logic [CNT_W-1:0] lo_code,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic             cts_n,
    input  logic             dsr_n,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_allow
);
    localparam int NUM_THR = 2;

    logic [CNT_W-1:0] codes  [NUM_THR];
    logic [CNT_W-1:0] levels [NUM_THR];
    logic [CNT_W-1:0] hi_lvl;
    logic [CNT_W-1:0] lo_lvl;
    logic             halt_q;
    logic [1:0]       clr_sync;
    modem_pins_t      pins_q;

    assign codes[0] = hi_code;
    assign codes[1] = lo_code;

    generate
        for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
            rxwm_level_decode #(
                .CODE_W (CNT_W),
                .LVL_W  (CNT_W),
                .MAX_LVL(MAX_LVL)
            ) u_dec (
                .code (codes[t]),
                .level(levels[t])
            );
        end
    endgenerate

    assign hi_lvl = levels[0];
    assign lo_lvl = levels[1];

    rxwm_hysteresis #(
        .CNT_W(CNT_W)
    ) u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (fc_en),
        .count   (fifo_count),
        .hi_level(hi_lvl),
        .lo_level(lo_lvl),
        .halt_q  (halt_q)
    );

    rxwm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({dsr_n, cts_n}),
        .sync_out(clr_sync)
    );

    rxwm_pin_mux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (fc_en),
        .map_sel (map_sel_e'(map_sel)),
        .halt    (halt_q),
        .sw_rts  (sw_rts),
        .sw_dtr  (sw_dtr),
        .cts_s_n (clr_sync[0]),
        .dsr_s_n (clr_sync[1]),
        .pins_q  (pins_q),
        .tx_allow(tx_allow)
    );

    assign rts_n = pins_q.rts_n;
    assign dtr_n = pins_q.dtr_n;
endmodule

// File: rtl/rxwm_flow_ctrl_chk.sv
// Module: property checker for rxwm_flow_ctrl, attached by bind below.
// Assumes: synchronous active-low reset; armed one cycle after reset so no
// $past reaches back before reset was released.
module rxwm_flow_ctrl_chk #(
    parameter int CNT_W   = 8,
    parameter int MAX_LVL = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fc_en,
    input logic             map_sel,
    input logic [CNT_W-1:0] fifo_count,
    input logic [CNT_W-1:0] hi_lvl,
    input logic [CNT_W-1:0] lo_lvl,
    input logic             halt_q,
    input logic             sw_rts,
    input logic             sw_dtr,
    input logic             rts_n,
    input logic             dtr_n,
    input logic             tx_allow
);
    logic armed;

    // Arm the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_lvl >= CNT_W'(1)) && (hi_lvl <= CNT_W'(MAX_LVL)) &&
        (lo_lvl >= CNT_W'(1)) && (lo_lvl <= CNT_W'(MAX_LVL)));

    assert_rise_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $rose(halt_q) |-> $past(fifo_count) >= $past(hi_lvl));

    assert_fall_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $fell(halt_q) && $past(fc_en) |-> $past(fifo_count) <= $past(lo_lvl));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !halt_q);

    assert_free_rts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        map_sel |=> rts_n == !$past(sw_rts));

    assert_free_dtr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !map_sel |=> dtr_n == !$past(sw_dtr));

    assert_tx_allow_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |-> tx_allow);
endmodule

bind rxwm_flow_ctrl rxwm_flow_ctrl_chk #(
    .CNT_W  (CNT_W),
    .MAX_LVL(MAX_LVL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_en     (fc_en),
    .map_sel   (map_sel),
    .fifo_count(fifo_count),
    .hi_lvl    (hi_lvl),
    .lo_lvl    (lo_lvl),
    .halt_q    (halt_q),
    .sw_rts    (sw_rts),
    .sw_dtr    (sw_dtr),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n),
    .tx_allow  (tx_allow)
);

// File: tb/rxwm_flow_ctrl_tb.sv
module rxwm_flow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fc_en = 1'b0;
    logic       map_sel = 1'b0;
    logic [7:0] fifo_count = '0;
    logic [7:0] hi_code = 8'd100;
    logic [7:0] lo_code = 8'd10;
    logic       sw_rts = 1'b0;
    logic       sw_dtr = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       rts_n;
    logic       dtr_n;
    logic       tx_allow;

    int n_tests = 0;
    int n_fail  = 0;
    bit m_halt  = 1'b0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    rxwm_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .map_sel(map_sel),
        .fifo_count(fifo_count), .hi_code(hi_code), .lo_code(lo_code),
        .sw_rts(sw_rts), .sw_dtr(sw_dtr), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .tx_allow(tx_allow)
    );

    function automatic int eff_level(input logic [7:0] code);
        if (code <= 8'd1)   return 1;
        if (code > 8'd128)  return 128;
        return int'(code);
    endfunction

    function automatic bit next_halt(input bit cur);
        if (!fc_en) return 1'b0;
        if (int'(fifo_count) >= eff_level(hi_code)) return 1'b1;
        if (int'(fifo_count) <= eff_level(lo_code)) return 1'b0;
        return cur;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Hold the driven inputs for three edges, update the model, check all outputs.
    task automatic settle_and_check(input string tag);
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_halt = next_halt(m_halt);
        check(rts_n, (fc_en && !map_sel) ? logic'(m_halt) : !sw_rts, {tag, " R7 rts_n"});
        check(dtr_n, (fc_en &&  map_sel) ? logic'(m_halt) : !sw_dtr, {tag, " R7 dtr_n"});
        check(tx_allow, !fc_en || !(map_sel ? dsr_n : cts_n), {tag, " R9 tx_allow"});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rts_n, 1'b0, "R1 reset rts_n");
        check(dtr_n, 1'b0, "R1 reset dtr_n");
        check(tx_allow, 1'b1, "R1 reset tx_allow");
        rst_n = 1'b1;
        sw_rts = 1'b1; sw_dtr = 1'b1; cts_n = 1'b0; dsr_n = 1'b0;
        settle_and_check("R8 disabled");

        // R2: code 0 and code 1 both mean one entry
        fc_en = 1'b1; hi_code = 8'd0; lo_code = 8'd0; fifo_count = 8'd1;
        settle_and_check("R2 code0");
        check(rts_n, 1'b1, "R2 code0 stops at 1");
        fifo_count = 8'd0; hi_code = 8'd1;
        settle_and_check("R2 resume");
        check(rts_n, 1'b0, "R2 count0 below level1");
        fifo_count = 8'd1;
        settle_and_check("R2 code1");
        check(rts_n, 1'b1, "R2 code1 stops at 1");

        // R3: clamp above 0x80
        fifo_count = 8'd0; lo_code = 8'd5; hi_code = 8'hFF;
        settle_and_check("R3 clamp low");
        fifo_count = 8'd127;
        settle_and_check("R3 below 128");
        check(rts_n, 1'b0, "R3 127 under clamped 128");
        fifo_count = 8'd128;
        settle_and_check("R3 at 128");
        check(rts_n, 1'b1, "R3 128 hits clamped level");

        // R4/R5: hysteresis hold between levels
        hi_code = 8'd80; lo_code = 8'd20; fifo_count = 8'd50;
        settle_and_check("R5 hold high");
        check(rts_n, 1'b1, "R5 hold keeps stop");
        fifo_count = 8'd20;
        settle_and_check("R5 at low");
        check(rts_n, 1'b0, "R5 resume at low");
        fifo_count = 8'd79;
        settle_and_check("R5 hold low");
        check(rts_n, 1'b0, "R5 hold keeps resume");
        fifo_count = 8'd80;
        settle_and_check("R4 at high");
        check(rts_n, 1'b1, "R4 stop at high");

        // R6: overlapping thresholds, stop wins
        fifo_count = 8'd0;
        settle_and_check("R6 clear");
        hi_code = 8'd10; lo_code = 8'd30; fifo_count = 8'd15;
        settle_and_check("R6 overlap");
        check(rts_n, 1'b1, "R6 stop wins");

        // R7: move handshake to DTR while stopped
        map_sel = 1'b1; sw_rts = 1'b0;
        settle_and_check("R7 swap");
        check(dtr_n, 1'b1, "R7 dtr carries stop");
        check(rts_n, 1'b1, "R7 rts follows sw_rts=0");

        // R10: threshold change latency, pin moves on second edge
        map_sel = 1'b0; hi_code = 8'd100; lo_code = 8'd10; fifo_count = 8'd50;
        settle_and_check("R10 setup");
        fifo_count = 8'd5;
        settle_and_check("R10 resume");
        fifo_count = 8'd50;
        settle_and_check("R10 hold");
        hi_code = 8'd40;
        @(posedge clk); @(negedge clk);
        check(rts_n, 1'b0, "R10 one edge no move");
        @(posedge clk); @(negedge clk);
        check(rts_n, 1'b1, "R10 two edges moved");
        m_halt = 1'b1;

        // R9: two-flop latency on clear input
        cts_n = 1'b0;
        settle_and_check("R9 setup");
        cts_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(tx_allow, 1'b1, "R9 one edge old");
        @(posedge clk); @(negedge clk);
        check(tx_allow, 1'b0, "R9 two edges new");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            fc_en      = ($urandom % 8) != 0;
            map_sel    = $urandom % 2;
            sw_rts     = $urandom % 2;
            sw_dtr     = $urandom % 2;
            cts_n      = $urandom % 2;
            dsr_n      = $urandom % 2;
            fifo_count = 8'($urandom % 129);
            if (($urandom % 4) == 0) begin
                hi_code = 8'($urandom % 256);
                lo_code = 8'($urandom % 256);
            end
            settle_and_check("R4/R5/R8 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule